// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM. A one-cycle start pulse carries a 6-bit word address. The block then runs the whole pin sequence. It frames the access with chip select, shifts out an 11-bit read command, turns the data line around and clocks in sixteen data bits. When the access is over it presents the word with its two bytes exchanged and raises done for one cycle.

Every pin level the block drives lasts a whole number of "steps". A step is a parameterised count of system clocks, at least one. The serial clock therefore never runs faster than half the system clock. One access takes a fixed number of steps, so the host can predict the latency exactly. The block accepts a new start only while it is idle.

Top module: `sprom_word_fetch`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, ee_cs, ee_sck and ee_sdo are low, and busy and done are low.
- R2: A start seen while idle is accepted. busy goes high at the next edge. The access opens with one step of chip select low, followed by chip select high with the clock low.
- R3: The command is shifted MSB first as 11 bits: two zero bits, then 1, 1, 0, then the 6-bit address, MSB first.
- R4: Each command bit is placed on ee_sdo while ee_sck is low. It then stays constant for the clock-high step and the clock-low step that follow.
- R5: After the command, ee_sdo returns low. Sixteen data bits are read MSB first. Each is sampled from ee_sdi at the end of its clock-high step. One access produces exactly 27 rising edges of ee_sck.
- R6: ee_sck rises only while ee_cs is high. ee_cs falls after the sixteenth data bit, while ee_sck has been low for at least one cycle.
- R7: The presented word is the shifted-in value with its bytes exchanged. The first bit read lands in bit 7 and the last bit read lands in bit 8.
- R8: done is high for exactly one cycle, in the cycle where busy has just fallen. The word stays unchanged until the next accepted access completes.
- R9: A start that arrives while busy is ignored. It changes neither the ongoing command, nor the result, nor the latency, and it starts no second access.
- R10: Every ee_sck level lasts at least STEP_CYCLES clocks. done rises exactly 69 × STEP_CYCLES clock edges after the edge that accepted the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to read a word |
| word_addr | input | 6 | Word address, sampled when start is accepted |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle pulse: word_out is valid |
| word_out | output | 16 | Byte-exchanged word from the last access |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sck | output | 1 | EEPROM shift clock |
| ee_sdo | output | 1 | Serial data towards the EEPROM |
| ee_sdi | input | 1 | Serial data from the EEPROM |

## Verification
The checker assumes that start and ee_sdi are synchronous to clk. It also assumes that ee_sdi changes only while ee_sck is low, so the value sampled at the end of a clock-high step is settled. The bench's EEPROM model meets this: it updates ee_sdi only on falling edges of ee_sck, and all host inputs are driven on the falling edge of clk. The model also decodes the command it receives and serves its data from a computed function of the decoded address. The data check therefore depends on a correct command as well.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  // Sequencer phases; every non-idle phase lasts one step.
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PRE,   // chip select low, one step
    PH_SEL,   // chip select high, clock low
    PH_CSET,  // command bit placed, clock low
    PH_CHI,   // command bit, clock high
    PH_CLO,   // command bit, clock low again
    PH_TURN,  // data line back low
    PH_RHI,   // read clock high, sample at end
    PH_RLO,   // read clock low
    PH_FIN    // chip select dropped
  } phase_e;

  localparam int          CMD_PAD  = 2;
  localparam logic [2:0]  RD_HEAD  = 3'b110;  // start bit, then read opcode

endpackage

// File: rtl/sprom_step_timer.sv
module sprom_step_timer #(
  parameter int STEP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_end
);
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign step_end = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || step_end) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sprom_seq_fsm.sv
module sprom_seq_fsm
  import sprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              step_end,
  output logic              active,
  output logic              sample,
  output logic              finish,
  output logic              ee_cs,
  output logic              ee_sck,
  output logic              ee_sdo
);
  localparam int CMD_W = CMD_PAD + 3 + ADDR_W;
  localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int BIT_W = $clog2(MAXB);
  localparam logic [BIT_W-1:0] CMD_LAST = BIT_W'(CMD_W - 1);
  localparam logic [BIT_W-1:0] RD_LAST  = BIT_W'(DATA_W - 1);

  phase_e             ph_q, ph_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic               accept;

  assign accept = (ph_q == PH_IDLE) && start;
  assign active = (ph_q != PH_IDLE);
  assign sample = (ph_q == PH_RHI) && step_end;
  assign finish = (ph_q == PH_FIN) && step_end;

  always_comb begin
    ph_d  = ph_q;
    bit_d = bit_q;
    cmd_d = cmd_q;
    if (accept) begin
      ph_d  = PH_PRE;
      bit_d = '0;
      cmd_d = {{CMD_PAD{1'b0}}, RD_HEAD, word_addr};
    end else if (step_end) begin
      case (ph_q)
        PH_PRE:  ph_d = PH_SEL;
        PH_SEL:  begin ph_d = PH_CSET; bit_d = '0; end
        PH_CSET: ph_d = PH_CHI;
        PH_CHI:  ph_d = PH_CLO;
        PH_CLO: begin
          cmd_d = {cmd_q[CMD_W-2:0], 1'b0};
          if (bit_q == CMD_LAST) ph_d = PH_TURN;
          else begin ph_d = PH_CSET; bit_d = bit_q + 1'b1; end
        end
        PH_TURN: begin ph_d = PH_RHI; bit_d = '0; end
        PH_RHI:  ph_d = PH_RLO;
        PH_RLO: begin
          if (bit_q == RD_LAST) ph_d = PH_FIN;
          else begin ph_d = PH_RHI; bit_d = bit_q + 1'b1; end
        end
        PH_FIN:  ph_d = PH_IDLE;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      bit_q <= '0;
      cmd_q <= '0;
    end else begin
      ph_q  <= ph_d;
      bit_q <= bit_d;
      cmd_q <= cmd_d;
    end
  end

  // Pin decode from the phase register
  always_comb begin
    ee_cs  = 1'b0;
    ee_sck = 1'b0;
    ee_sdo = 1'b0;
    case (ph_q)
      PH_SEL, PH_TURN, PH_RLO: ee_cs = 1'b1;
      PH_CSET, PH_CLO: begin ee_cs = 1'b1; ee_sdo = cmd_q[CMD_W-1]; end
      PH_CHI: begin ee_cs = 1'b1; ee_sck = 1'b1; ee_sdo = cmd_q[CMD_W-1]; end
      PH_RHI: begin ee_cs = 1'b1; ee_sck = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sprom_rx_shifter.sv
module sprom_rx_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              finish,
  input  logic              sdi,
  output logic [DATA_W-1:0] word_out,
  output logic              done
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] raw_q, raw_d;
  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] word_q, word_d;
  logic              done_q;

  // Byte order reversal of the raw shift value
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign swapped[8*b +: 8] = raw_q[8*(NBYTES-1-b) +: 8];
  end

  always_comb begin
    raw_d  = raw_q;
    word_d = word_q;
    if (sample) raw_d  = {raw_q[DATA_W-2:0], sdi};
    if (finish) word_d = swapped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      word_q <= word_d;
      done_q <= finish;
    end
  end

  assign word_out = word_q;
  assign done     = done_q;
endmodule

// File: rtl/sprom_word_fetch.sv
module sprom_word_fetch #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int STEP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] word_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] word_out,
  output logic              ee_cs,
  output logic              ee_sck,
  output logic              ee_sdo,
  input  logic              ee_sdi
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       step_end, active, sample, finish;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  sprom_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (active),
    .step_end (step_end)
  );

  sprom_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .word_addr (word_addr),
    .step_end  (step_end),
    .active    (active),
    .sample    (sample),
    .finish    (finish),
    .ee_cs     (ee_cs),
    .ee_sck    (ee_sck),
    .ee_sdo    (ee_sdo)
  );

  sprom_rx_shifter #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sample   (sample),
    .finish   (finish),
    .sdi      (ee_sdi),
    .word_out (word_out),
    .done     (done)
  );

  assign busy = active;
endmodule

// File: rtl/sprom_word_fetch_chk.sv
module sprom_word_fetch_chk #(
  parameter int STEP_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic ee_cs,
  input logic ee_sck,
  input logic ee_sdo
);
  localparam int RUN_W = $clog2(STEP_CYCLES + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MIN = RUN_W'(STEP_CYCLES);

  logic             sck_prev_q;
  logic [RUN_W-1:0] run_q;

  // Length of the current ee_sck level, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      run_q      <= RUN_MIN;
    end else if (ee_sck != sck_prev_q) begin
      sck_prev_q <= ee_sck;
      run_q      <= RUN_W'(1);
    end else if (run_q < RUN_MIN) begin
      run_q      <= run_q + 1'b1;
    end
  end

  assert_sck_level_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sck != sck_prev_q) |-> (run_q >= RUN_MIN));

  assert_sck_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sck) |-> ee_cs);

  assert_cs_drop_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> (!ee_sck && !$past(ee_sck)));

  assert_sdo_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sck |-> $stable(ee_sdo));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && !ee_cs));

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sck && !ee_sdo));
endmodule

bind sprom_word_fetch sprom_word_fetch_chk #(.STEP_CYCLES(STEP_CYCLES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .ee_cs  (ee_cs),
  .ee_sck (ee_sck),
  .ee_sdo (ee_sdo)
);

// File: tb/sprom_word_fetch_test.sv
module sprom_word_fetch_test;
  localparam int STEP   = 4;
  localparam int LAT    = 69 * STEP;
  localparam int NVEC   = 8;
  localparam logic [5:0] VEC_ADDR [NVEC] = '{6'd0, 6'd1, 6'd21, 6'd42, 6'd63, 6'd32, 6'd5, 6'd30};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  word_addr = '0;
  logic        busy, done, ee_cs, ee_sck, ee_sdo, ee_sdi;
  logic [15:0] word_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sprom_word_fetch #(.STEP_CYCLES(STEP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_addr(word_addr),
    .busy(busy), .done(done), .word_out(word_out),
    .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_sdo(ee_sdo), .ee_sdi(ee_sdi)
  );

  function automatic logic [15:0] rom_word(input logic [5:0] a);
    return {2'b01, a, ~a, 2'b10};
  endfunction

  function automatic logic [15:0] swap16(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  // EEPROM model
  logic [10:0] m_rx;
  int          m_rise, m_rd, m_xact;
  logic [10:0] last_cmd;
  int          last_rise;
  logic        m_sdi = 1'b0;
  assign ee_sdi = m_sdi;

  initial begin m_rx = '0; m_rise = 0; m_rd = 0; m_xact = 0; last_cmd = '0; last_rise = 0; end

  always @(posedge ee_cs) begin m_rx = '0; m_rise = 0; m_rd = 0; m_sdi = 1'b0; end
  always @(posedge ee_sck) if (ee_cs) begin
    if (m_rise < 11) m_rx = {m_rx[9:0], ee_sdo};
    m_rise++;
  end
  always @(negedge ee_sck) if (ee_cs && m_rise >= 11 && m_rd < 16) begin
    m_sdi = rom_word(m_rx[5:0])[15 - m_rd];
    m_rd++;
  end
  always @(negedge ee_cs) begin last_cmd = m_rx; last_rise = m_rise; m_xact++; end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One access; optionally pulse a stray start at cycle inj_at with inj_addr
  task automatic do_read(input logic [5:0] a, input int inj_at, input logic [5:0] inj_addr,
                         output int lat);
    int n;
    @(negedge clk); start = 1'b1; word_addr = a;
    @(posedge clk); #1 start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    n = 0;
    do begin
      @(posedge clk); n++;
      #1;
      if (n == STEP) check(ee_cs == 1'b1 && ee_sck == 1'b0, "R2", "cs high after pre step",
                           {ee_cs, ee_sck}, 2);
      if (n == inj_at) begin start = 1'b1; word_addr = inj_addr; end
      if (n == inj_at + 1) begin start = 1'b0; word_addr = a; end
    end while (!done && n < 4 * LAT);
    lat = n;
  endtask

  initial begin : main
    int lat;
    logic [15:0] held;
    int x0;
    #1;
    check(ee_cs == 0 && ee_sck == 0 && ee_sdo == 0, "R1", "pins in reset", {ee_cs, ee_sck, ee_sdo}, 0);
    check(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ee_cs == 0 && ee_sck == 0 && busy == 0 && done == 0, "R1", "idle after reset",
          {ee_cs, ee_sck, busy, done}, 0);
    check(word_out == 16'h0, "R1", "word after reset", word_out, 0);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [5:0] a;
      a = VEC_ADDR[i];
      x0 = m_xact;
      do_read(a, -10, 6'd0, lat);
      check(lat == LAT, "R10", "done latency", lat, LAT);
      check(last_cmd == {2'b00, 3'b110, a}, "R3", "command bits", last_cmd, {2'b00, 3'b110, a});
      check(last_rise == 27, "R5", "rising edges", last_rise, 27);
      check(word_out == swap16(rom_word(a)), "R7", "byte-swapped word", word_out, swap16(rom_word(a)));
      check(m_xact == x0 + 1, "R6", "one cs frame", m_xact - x0, 1);
      @(posedge clk); #1;
      check(done == 1'b0, "R8", "done single cycle", done, 0);
    end

    // Hold: result stays while idle
    held = word_out;
    repeat (25) @(posedge clk);
    #1;
    check(word_out == held && done == 0 && busy == 0, "R8", "word held while idle", word_out, held);

    // Stray start while busy
    x0 = m_xact;
    do_read(6'd13, 100, 6'd50, lat);
    check(lat == LAT, "R9", "latency with stray start", lat, LAT);
    check(word_out == swap16(rom_word(6'd13)), "R9", "word with stray start", word_out, swap16(rom_word(6'd13)));
    check(last_cmd == {5'b00110, 6'd13}, "R9", "command with stray start", last_cmd, {5'b00110, 6'd13});
    repeat (10) @(posedge clk);
    #1;
    check(busy == 0 && m_xact == x0 + 1, "R9", "no second access", m_xact - x0, 1);

    // Reset in the middle of an access
    @(negedge clk); start = 1'b1; word_addr = 6'd7;
    @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(ee_cs == 0 && ee_sck == 0 && busy == 0 && done == 0, "R1", "mid-access reset",
          {ee_cs, ee_sck, busy, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(6'd44, -10, 6'd0, lat);
    check(lat == LAT && word_out == swap16(rom_word(6'd44)), "R7", "read after reset",
          word_out, swap16(rom_word(6'd44)));

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule